// File: doc/BRIEF.md
# Recency-Stack Replacement State with Selectable Insertion

This block holds the replacement state of a single 16-way cache set as a full recency stack: an ordered list of way numbers from the most recently used slot (position 0) to the least recently used slot (position 15). The surrounding cache controller presents one access per cycle. Each access carries a hit flag and, on a hit, the way that matched. On a hit the block moves that way to the front of the stack. On a miss the controller fills the way shown on `victim_way`, which is always the way in the last slot. The block then records where the newly filled line sits in the stack.

That placement is chosen by `ins_mode`, separately from victim choice. Classic insertion puts the new line at the front. LRU-slot insertion leaves it in the last slot, so a line that is never reused is the next victim. Bimodal insertion puts the line at the front only about once in 32 misses and otherwise leaves it in the last slot. The 1-in-32 draw comes from an internal 16-bit LFSR that steps once per miss. This lets a cache resist thrashing when its working set is larger than the set, while still letting the resident lines age out.

Top module: `rsr_top`

## Requirements
- R1: After reset, slot p of the stack holds way p for every p from 0 to 15. `order_dbg[4p+3:4p]` shows slot p, and slot 0 is the most recently used.
- R2: `victim_way` always equals the way in slot 15 of the current stack, as a combinational function of the stored state.
- R3: An access with `acc_valid`=1 and `acc_hit`=1 to the way in slot p works as follows, starting at the next clock edge. That way goes to slot 0. The ways that were in slots 0..p-1 each move one slot down. Slots above p keep their ways.
- R4: `ins_mode` encoding is 0 = classic, 1 = LRU-slot, 2 = bimodal, 3 = classic. On a miss in classic mode the victim goes to slot 0 and every other way moves one slot down.
- R5: On a miss in LRU-slot mode (`ins_mode`=1) the stack is unchanged. The filled line keeps the victim's slot 15.
- R6: On a miss in bimodal mode (`ins_mode`=2) the fill behaves as classic (R4) when bits [4:0] of the LFSR are all zero before the miss. Otherwise it behaves as LRU-slot (R5).
- R7: The LFSR is 16 bits wide and resets to parameter SEED (default 16'hACE1). Its next value is `{s[14:0], s[15]^s[13]^s[12]^s[10]}`. It steps once on every miss in every mode. It does not step on hits or idle cycles.
- R8: A cycle with `acc_valid`=0 leaves the stack unchanged, whatever `acc_hit`, `acc_way` and `ins_mode` are.
- R9: The stack always holds each of the ways 0..15 exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access to this set occurs this cycle |
| acc_hit | input | 1 | The access hit (1) or missed (0) |
| acc_way | input | 4 | Way that hit; ignored on a miss |
| ins_mode | input | 2 | Insertion mode for misses |
| victim_way | output | 4 | Way to replace on a miss (slot 15) |
| order_dbg | output | 64 | Recency stack, slot p at bits [4p+3:4p] |

## Verification
Hits are applied at the front slot, at a middle slot and at the last slot. The front-slot hit shows that promotion with nothing ahead is a no-op. The middle-slot hit shows that only the slots ahead shift. The last-slot hit exercises the full-length shift. Miss runs in modes 0 and 3 and in mode 1 separate a front-inserting fill from one that leaves the stack as it was. A following hit on the LRU-inserted line confirms that the line can still be promoted. A long bimodal run mixes misses with hits and idle cycles. Against an independently stepped LFSR model, it shows both fill outcomes and confirms that only misses advance the random source. Idle cycles that carry hit-like inputs separate gated updates from ungated ones.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int WAYS    = 16;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int ORD_W   = WAYS * WAY_W;
  localparam int LFSR_W  = 16;

  typedef enum logic [1:0] {
    INS_MRU     = 2'd0,
    INS_LRU     = 2'd1,
    INS_BIMODAL = 2'd2,
    INS_ALT_MRU = 2'd3
  } ins_mode_e;

  // slot that currently holds a given way
  function automatic logic [WAY_W-1:0] slot_of(input logic [ORD_W-1:0] ord,
                                               input logic [WAY_W-1:0] way);
    logic [WAY_W-1:0] s;
    s = '0;
    for (int i = 0; i < WAYS; i++)
      if (ord[i*WAY_W +: WAY_W] == way) s = WAY_W'(i);
    return s;
  endfunction

  // x^16 + x^14 + x^13 + x^11 + 1, shifting left
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic is_perm(input logic [ORD_W-1:0] ord);
    logic [WAYS-1:0] seen;
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[ord[i*WAY_W +: WAY_W]] = 1'b1;
    return &seen;
  endfunction
endpackage

// File: rtl/rsr_lfsr.sv
module rsr_lfsr #(
  parameter int W = rsr_pkg::LFSR_W,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] SEED_SAFE = (SEED == '0) ? W'(1) : SEED;

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= SEED_SAFE;
    else if (step) state_q <= rsr_pkg::lfsr_step(state_q);
  end

  assign value = state_q;
endmodule

// File: rtl/rsr_stack.sv
module rsr_stack #(
  parameter int WAYS  = rsr_pkg::WAYS,
  parameter int WAY_W = rsr_pkg::WAY_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  promote,   // move one way to slot 0
  input  logic                  from_hit,  // source is the hit way, else slot WAYS-1
  input  logic [WAY_W-1:0]      hit_way,
  output logic [WAY_W-1:0]      lru_way,
  output logic [WAYS*WAY_W-1:0] ord_flat
);
  localparam int LAST = WAYS - 1;

  logic [WAY_W-1:0] ord_q [WAYS];
  logic [WAY_W-1:0] ord_d [WAYS];
  logic [WAY_W-1:0] src_slot;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_flat
      assign ord_flat[g*WAY_W +: WAY_W] = ord_q[g];
    end
  endgenerate

  assign lru_way  = ord_q[LAST];
  assign src_slot = from_hit ? rsr_pkg::slot_of(ord_flat, hit_way) : WAY_W'(LAST);

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      ord_d[i] = ord_q[i];
      if (promote) begin
        if (i == 0)                      ord_d[i] = ord_q[src_slot];
        else if (WAY_W'(i) <= src_slot)  ord_d[i] = ord_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WAYS; i++) begin
      if (!rst_n) ord_q[i] <= WAY_W'(i);
      else        ord_q[i] <= ord_d[i];
    end
  end
endmodule

// File: rtl/rsr_top.sv
module rsr_top #(
  parameter int WAYS     = rsr_pkg::WAYS,
  parameter int WAY_W    = rsr_pkg::WAY_W,
  parameter int LFSR_W   = rsr_pkg::LFSR_W,
  parameter int THR_BITS = 5,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_hit,
  input  logic [WAY_W-1:0]      acc_way,
  input  logic [1:0]            ins_mode,
  output logic [WAY_W-1:0]      victim_way,
  output logic [WAYS*WAY_W-1:0] order_dbg
);
  import rsr_pkg::*;

  ins_mode_e         mode;
  logic              hit_evt, miss_evt, lucky, fill_mru, promote;
  logic [LFSR_W-1:0] lfsr_val;

  assign mode     = ins_mode_e'(ins_mode);
  assign hit_evt  = acc_valid &  acc_hit;
  assign miss_evt = acc_valid & ~acc_hit;
  assign lucky    = (lfsr_val[THR_BITS-1:0] == '0);

  always_comb begin
    unique case (mode)
      INS_LRU:     fill_mru = 1'b0;
      INS_BIMODAL: fill_mru = miss_evt & lucky;
      default:     fill_mru = miss_evt;
    endcase
  end

  assign promote = hit_evt | fill_mru;

  rsr_lfsr #(.W(LFSR_W), .SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (miss_evt),
    .value (lfsr_val)
  );

  rsr_stack #(.WAYS(WAYS), .WAY_W(WAY_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .promote  (promote),
    .from_hit (acc_hit),
    .hit_way  (acc_way),
    .lru_way  (victim_way),
    .ord_flat (order_dbg)
  );
endmodule

// File: rtl/rsr_chk.sv
module rsr_chk #(
  parameter int WAYS   = rsr_pkg::WAYS,
  parameter int WAY_W  = rsr_pkg::WAY_W,
  parameter int LFSR_W = rsr_pkg::LFSR_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_valid,
  input logic                  hit_evt,
  input logic                  miss_evt,
  input logic                  fill_mru,
  input logic [1:0]            ins_mode,
  input logic [WAY_W-1:0]      acc_way,
  input logic [WAY_W-1:0]      victim_way,
  input logic [LFSR_W-1:0]     lfsr_val,
  input logic [WAYS*WAY_W-1:0] order_dbg
);
  // R9
  perm_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsr_pkg::is_perm(order_dbg));

  // R3
  hit_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> order_dbg[WAY_W-1:0] == $past(acc_way));

  // R4
  classic_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && (ins_mode == 2'd0 || ins_mode == 2'd3)) |=> order_dbg[WAY_W-1:0] == $past(victim_way));

  // R5
  lru_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && ins_mode == 2'd1) |=> $stable(order_dbg));

  // R6
  bimodal_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && ins_mode == 2'd2 && !fill_mru) |=> $stable(order_dbg));

  // R7
  lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> lfsr_val != $past(lfsr_val));

  // R7
  lfsr_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_evt |=> $stable(lfsr_val));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(order_dbg));
endmodule

bind rsr_top rsr_chk #(.WAYS(WAYS), .WAY_W(WAY_W), .LFSR_W(LFSR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .hit_evt    (hit_evt),
  .miss_evt   (miss_evt),
  .fill_mru   (fill_mru),
  .ins_mode   (ins_mode),
  .acc_way    (acc_way),
  .victim_way (victim_way),
  .lfsr_val   (lfsr_val),
  .order_dbg  (order_dbg)
);

// File: tb/rsr_top_test.sv
`timescale 1ns/1ps
module rsr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_hit = 1'b0;
  logic [3:0]  acc_way = '0;
  logic [1:0]  ins_mode = '0;
  logic [3:0]  victim_way;
  logic [63:0] order_dbg;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  int          model [16];
  logic [15:0] m_lfsr = 16'hACE1;
  int          bim_front = 0;
  int          bim_tail = 0;

  always #10 clk = ~clk;

  rsr_top uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_way(acc_way), .ins_mode(ins_mode), .victim_way(victim_way),
    .order_dbg(order_dbg)
  );

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int i = 0; i < 16; i++) f[i*4 +: 4] = 4'(model[i]);
    return f;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_perm(input string tag);
    logic [15:0] seen = '0;
    for (int i = 0; i < 16; i++) seen[order_dbg[i*4 +: 4]] = 1'b1;
    check(tag, 64'(seen), 64'hFFFF);
  endtask

  // bring slot p to the front, shifting those ahead of it
  task automatic model_front(input int p);
    int w = model[p];
    for (int i = p; i > 0; i--) model[i] = model[i-1];
    model[0] = w;
  endtask

  task automatic access(input bit valid, input bit hit, input int way,
                        input int mode, input string tag);
    @(negedge clk);
    check("R2", 64'(victim_way), 64'(model[15]));
    acc_valid = valid; acc_hit = hit; acc_way = 4'(way); ins_mode = 2'(mode);
    if (valid && hit) begin
      for (int p = 0; p < 16; p++) if (model[p] == way) begin model_front(p); break; end
    end else if (valid) begin
      bit front;
      if (mode == 2) begin
        front = (m_lfsr[4:0] == 5'd0);
        if (front) bim_front++; else bim_tail++;
      end else front = (mode != 1);
      if (front) model_front(15);
      m_lfsr = {m_lfsr[14:0], ^(m_lfsr & 16'hB400)};
    end
    @(negedge clk);
    acc_valid = 1'b0;
    check(tag, order_dbg, model_flat());
  endtask

  task automatic test_reset();
    for (int i = 0; i < 16; i++) model[i] = i;
    check("R1", order_dbg, 64'hFEDCBA9876543210);
    check("R2", 64'(victim_way), 64'd15);
    check_perm("R9");
  endtask

  task automatic test_hits();
    access(1, 1, 7, 0, "R3");   // middle slot
    access(1, 1, 7, 0, "R3");   // already at front
    access(1, 1, 15, 1, "R3");  // last slot, mode must not matter
    access(1, 1, 3, 2, "R3");
    check_perm("R9");
  endtask

  task automatic test_classic();
    for (int k = 0; k < 5; k++) access(1, 0, 0, 0, "R4");
    for (int k = 0; k < 4; k++) access(1, 0, 0, 3, "R4");
    check_perm("R9");
  endtask

  task automatic test_lru_slot();
    int v;
    for (int k = 0; k < 4; k++) access(1, 0, 0, 1, "R5");
    v = model[15];
    access(1, 1, v, 1, "R5");   // reuse lifts the line off the tail
    check("R5", 64'(order_dbg[3:0]), 64'(v));
  endtask

  task automatic test_idle();
    for (int k = 0; k < 4; k++) access(0, 1, k * 5, k, "R8");
    access(0, 0, 0, 0, "R8");
  endtask

  task automatic test_bimodal();
    for (int k = 0; k < 400; k++) begin
      if (k % 7 == 3)      access(1, 1, model[k % 16], 2, "R7");
      else if (k % 11 == 5) access(0, 0, 0, 2, "R7");
      else                 access(1, 0, 0, 2, "R6");
    end
    check("R6", 64'(bim_front > 0), 64'd1);
    check("R6", 64'(bim_tail > bim_front), 64'd1);
    check_perm("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_hits();
    test_classic();
    test_lru_slot();
    test_idle();
    test_bimodal();
    test_classic();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule